// File: doc/BRIEF.md
# Weighted and Strict-Priority Queue Scheduler

This block decides, cycle by cycle, which one of a port's output queues may send next. Each queue is configured with a service level from 0 to 8, or with the value 9, which places it in a strict-priority group. A service level is turned into a fixed 8-bit round-enable mask whose set bits are spread evenly over eight rounds. A 3-bit round counter steps through those rounds, and a round-robin pointer walks the weighted queues within a round. Non-empty strict-priority queues pre-empt all weighted traffic. Among strict-priority queues, the lowest queue number wins.

Software writes one queue entry at a time through an address/data/write-enable port. Each write carries the priority value, a flag marking the port's last queue, and a flag marking the last strict-priority queue. Entries may be rewritten while traffic flows. A write takes effect from the next clock edge. The consumer raises `ready` whenever it can take a grant. In the same cycle the block answers with a one-hot `grant` and `grant_valid`, formed combinationally from registered state and the current request bits.

Top module: `wsp_sched`

## Requirements
- R1: After reset every entry holds mask 00 with all flags clear, so no grant is issued. The weighted search then starts at queue 0 in round 0.
- R2: Priority values 0 to 8 map to these masks (hex): 0→00, 1→01, 2→11, 3→49, 4→55, 5→57, 6→77, 7→7F, 8→FF. Bit r of a queue's mask enables that queue in round r.
- R3: A queue with value 0 is never granted while it sits in the weighted group.
- R4: Value 9 makes a queue a strict-priority member. A non-empty queue of the strict group is granted ahead of every weighted queue, the lowest index first. A strict grant leaves the round counter and round-robin pointer unchanged.
- R5: A written value of 10 to 15 is stored as mask FF, not strict. In the cycle after that write, `prio_err` is high for one cycle; otherwise `prio_err` is low.
- R6: The first entry whose last-queue flag is set bounds the port. Queues above it are never granted. With no such flag, all queues take part.
- R7: The strict group is the set of queues holding value 9, at or below the first entry whose last-strict flag is set, and within the port. A value-9 queue above that bound is served as a weighted queue with mask FF. `strict_present` is high when any entry holds value 9.
- R8: Within a round, the weighted search resumes at the queue after the last granted weighted queue.
- R9: When no eligible weighted queue remains after the pointer in the current round, the search moves to the following rounds in order, from queue 0. The grant takes the first match, and the round counter takes that match's round.
- R10: `grant` is one-hot and names a non-empty queue when `grant_valid` is high. Both are zero when `ready` is low or when no queue is eligible.
- R11: A configuration write changes scheduling from the next cycle, without stopping traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Queue index written |
| cfg_prio | input | 4 | Priority value 0..15 (9 = strict) |
| cfg_last | input | 1 | Last-queue-of-port flag for the entry |
| cfg_slast | input | 1 | Last-strict-queue flag for the entry |
| q_nonempty | input | 8 | Per-queue non-empty bits |
| ready | input | 1 | Consumer can accept a grant this cycle |
| grant | output | 8 | One-hot selected queue |
| grant_valid | output | 1 | A grant is issued this cycle |
| prio_err | output | 1 | Invalid priority value was written last cycle |
| strict_present | output | 1 | At least one entry holds the strict value |

## Verification
The hardest case to reach from the ports is the round-wrap search. In that case no weighted queue is eligible after the pointer, and the grant has to come from a later round that skips several rounds whose masks have no bit set. The bench reaches it in two ways. It loads sparse masks (values 1, 2 and 3) on only one or two non-empty queues, and it runs long stretches of pseudo-random request patterns and live rewrites. A behavioural model tracks the round and pointer, and it is compared with the grant on every cycle. Exact grant counts over four full passes of weights 1, 2, 4 and 8 pin the mask table and the pass boundary.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
   localparam int ROUNDS     = 8;
   localparam int RW         = 3;
   localparam int PRIO_W     = 4;
   localparam logic [PRIO_W-1:0] STRICT_VAL = 4'd9;

   // round-enable mask for a configured value
   function automatic logic [ROUNDS-1:0] prio_to_mask(input logic [PRIO_W-1:0] v);
      logic [ROUNDS-1:0] m;
      case (v)
         4'd0:    m = 8'h00;
         4'd1:    m = 8'h01;
         4'd2:    m = 8'h11;
         4'd3:    m = 8'h49;
         4'd4:    m = 8'h55;
         4'd5:    m = 8'h57;
         4'd6:    m = 8'h77;
         4'd7:    m = 8'h7F;
         default: m = 8'hFF;
      endcase
      return m;
   endfunction

   function automatic logic prio_bad(input logic [PRIO_W-1:0] v);
      return v > STRICT_VAL;
   endfunction
endpackage

// File: rtl/wsp_cfg_table.sv
module wsp_cfg_table
   import wsp_pkg::*;
#(
   parameter int NQ = 8,
   localparam int AW = $clog2(NQ)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [AW-1:0]                addr,
   input  logic [PRIO_W-1:0]            prio,
   input  logic                         last_in,
   input  logic                         slast_in,
   output logic [NQ-1:0][ROUNDS-1:0]    masks,
   output logic [NQ-1:0]                strict_f,
   output logic [NQ-1:0]                last_f,
   output logic [NQ-1:0]                slast_f,
   output logic                         err
);
   for (genvar q = 0; q < NQ; q++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            masks[q]   <= '0;
            strict_f[q] <= 1'b0;
            last_f[q]  <= 1'b0;
            slast_f[q] <= 1'b0;
         end else if (we && addr == AW'(q)) begin
            masks[q]   <= prio_to_mask(prio);
            strict_f[q] <= (prio == STRICT_VAL);
            last_f[q]  <= last_in;
            slast_f[q] <= slast_in;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err <= 1'b0;
      else        err <= we && prio_bad(prio);
   end
endmodule

// File: rtl/wsp_scope.sv
module wsp_scope #(
   parameter int NQ = 8
) (
   input  logic [NQ-1:0] strict_f,
   input  logic [NQ-1:0] last_f,
   input  logic [NQ-1:0] slast_f,
   output logic [NQ-1:0] active,
   output logic [NQ-1:0] sgrp
);
   // prefix scan: a queue is inside a range until a boundary flag below it
   always_comb begin
      logic seen_last, seen_slast;
      seen_last  = 1'b0;
      seen_slast = 1'b0;
      for (int i = 0; i < NQ; i++) begin
         active[i]  = !seen_last;
         sgrp[i]    = strict_f[i] && !seen_slast && !seen_last;
         seen_last  = seen_last  | last_f[i];
         seen_slast = seen_slast | slast_f[i];
      end
   end
endmodule

// File: rtl/wsp_rr_pick.sv
module wsp_rr_pick
   import wsp_pkg::*;
#(
   parameter int NQ = 8,
   localparam int QW = $clog2(NQ)
) (
   input  logic [ROUNDS-1:0][NQ-1:0] elig,
   input  logic [RW-1:0]             rnd,
   input  logic [QW-1:0]             ptr,
   output logic                      found,
   output logic [QW-1:0]             pidx,
   output logic [RW-1:0]             pround
);
   // stage 0: current round after the pointer; stages 1..ROUNDS: later rounds from queue 0
   always_comb begin
      logic [RW-1:0] rr;
      found  = 1'b0;
      pidx   = '0;
      pround = rnd;
      for (int k = 0; k <= ROUNDS; k++) begin
         rr = rnd + RW'(k);
         for (int i = 0; i < NQ; i++) begin
            if (!found && (k != 0 || i > int'(ptr)) && elig[rr][i]) begin
               found  = 1'b1;
               pidx   = QW'(i);
               pround = rr;
            end
         end
      end
   end
endmodule

// File: rtl/wsp_sched.sv
module wsp_sched
   import wsp_pkg::*;
#(
   parameter int NQ = 8,
   localparam int QW = $clog2(NQ)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [QW-1:0]     cfg_addr,
   input  logic [PRIO_W-1:0] cfg_prio,
   input  logic              cfg_last,
   input  logic              cfg_slast,
   input  logic [NQ-1:0]     q_nonempty,
   input  logic              ready,
   output logic [NQ-1:0]     grant,
   output logic              grant_valid,
   output logic              prio_err,
   output logic              strict_present
);
   if (NQ < 2 || NQ > 16 || (1 << QW) != NQ) begin : g_bad_nq
      $error("wsp_sched: NQ must be a power of two from 2 to 16");
   end

   logic [NQ-1:0][ROUNDS-1:0] masks;
   logic [NQ-1:0]             strict_f, last_f, slast_f;
   logic [NQ-1:0]             active_q, sgrp;
   logic [NQ-1:0]             sreq, s_onehot, wcand;
   logic [ROUNDS-1:0][NQ-1:0] elig;
   logic [RW-1:0]             rnd_q, wround;
   logic [QW-1:0]             ptr_q, widx;
   logic                      wfound, s_hit;

   wsp_cfg_table #(.NQ(NQ)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .prio(cfg_prio),
      .last_in(cfg_last), .slast_in(cfg_slast), .masks(masks),
      .strict_f(strict_f), .last_f(last_f), .slast_f(slast_f), .err(prio_err)
   );

   wsp_scope #(.NQ(NQ)) u_scope (
      .strict_f(strict_f), .last_f(last_f), .slast_f(slast_f),
      .active(active_q), .sgrp(sgrp)
   );

   assign sreq     = sgrp & q_nonempty;
   assign s_onehot = sreq & (~sreq + NQ'(1));
   assign s_hit    = |sreq;
   assign wcand    = active_q & ~sgrp & q_nonempty;

   for (genvar r = 0; r < ROUNDS; r++) begin : g_rnd
      for (genvar i = 0; i < NQ; i++) begin : g_q
         assign elig[r][i] = wcand[i] & masks[i][r];
      end
   end

   wsp_rr_pick #(.NQ(NQ)) u_pick (
      .elig(elig), .rnd(rnd_q), .ptr(ptr_q),
      .found(wfound), .pidx(widx), .pround(wround)
   );

   always_comb begin
      grant = '0;
      if (ready) begin
         if (s_hit)       grant = s_onehot;
         else if (wfound) grant = NQ'(1) << widx;
      end
   end
   assign grant_valid    = ready && (s_hit || wfound);
   assign strict_present = |strict_f;

   // reset values make the first search begin at round 0, queue 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rnd_q <= RW'(ROUNDS - 1);
         ptr_q <= QW'(NQ - 1);
      end else if (ready && !s_hit && wfound) begin
         rnd_q <= wround;
         ptr_q <= widx;
      end
   end
endmodule

// File: rtl/wsp_sched_chk.sv
module wsp_sched_chk #(
   parameter int NQ = 8,
   localparam int QW = $clog2(NQ)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_we,
   input logic [3:0]    cfg_prio,
   input logic          ready,
   input logic [NQ-1:0] q_nonempty,
   input logic [NQ-1:0] grant,
   input logic          grant_valid,
   input logic          prio_err,
   input logic [NQ-1:0] active_q,
   input logic [NQ-1:0] sgrp,
   input logic [2:0]    rnd_q,
   input logic [QW-1:0] ptr_q
);
   // R10
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> ($onehot(grant) && (grant & ~q_nonempty) == '0));
   // R10
   idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (!grant_valid && grant == '0));
   // R4
   strict_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && (sgrp & q_nonempty) != '0) |-> (grant_valid && (grant & ~(sgrp & q_nonempty)) == '0));
   // R4
   strict_keeps_rr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && (grant & sgrp) != '0) |=> ($stable(rnd_q) && $stable(ptr_q)));
   // R6
   inactive_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> (grant & ~active_q) == '0);
   // R5
   bad_prio_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_prio > 4'd9) |=> prio_err);
   // R5
   no_false_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_prio > 4'd9) |=> !prio_err);
   // R9
   round_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_valid |=> ($stable(rnd_q) && $stable(ptr_q)));
endmodule

bind wsp_sched wsp_sched_chk #(.NQ(NQ)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_prio(cfg_prio), .ready(ready),
   .q_nonempty(q_nonempty), .grant(grant), .grant_valid(grant_valid),
   .prio_err(prio_err), .active_q(active_q), .sgrp(sgrp), .rnd_q(rnd_q), .ptr_q(ptr_q)
);

// File: tb/wsp_sched_bench.sv
module wsp_sched_bench;
   localparam int NQ = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_addr = '0;
   logic [3:0] cfg_prio = '0;
   logic       cfg_last = 1'b0, cfg_slast = 1'b0;
   logic [7:0] q_nonempty = '0;
   logic       ready = 1'b0;
   logic [7:0] grant;
   logic       grant_valid, prio_err, strict_present;

   always #4 clk = ~clk;

   wsp_sched #(.NQ(NQ)) u_wsp_sched (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_prio(cfg_prio), .cfg_last(cfg_last), .cfg_slast(cfg_slast),
      .q_nonempty(q_nonempty), .ready(ready), .grant(grant),
      .grant_valid(grant_valid), .prio_err(prio_err), .strict_present(strict_present)
   );

   int checks = 0, errors = 0;
   string tag = "R1";

   // behavioural reference state
   int m_prio[NQ];
   bit m_last[NQ], m_slast[NQ];
   int m_rnd, m_ptr;
   bit m_err;
   int cnt[NQ];

   function automatic int mask_of(int v);
      case (v)
         0: return 'h00; 1: return 'h01; 2: return 'h11; 3: return 'h49;
         4: return 'h55; 5: return 'h57; 6: return 'h77; 7: return 'h7F;
         default: return 'hFF;
      endcase
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NQ; i++) begin
         m_prio[i] = 0; m_last[i] = 0; m_slast[i] = 0;
      end
      m_rnd = 7; m_ptr = 7; m_err = 0;
   endtask

   // returns chosen queue or -1; sets is_strict and the round of a weighted pick
   task automatic model_pick(output int q, output bit is_strict, output int rr);
      bit act[NQ], sg[NQ];
      bit lastseen = 0, sl = 0;
      q = -1; is_strict = 0; rr = m_rnd;
      for (int i = 0; i < NQ; i++) begin
         act[i] = !lastseen;
         sg[i]  = (m_prio[i] == 9) && !sl && !lastseen;
         lastseen |= m_last[i];
         sl |= m_slast[i];
      end
      if (!ready) return;
      for (int i = 0; i < NQ; i++)
         if (q < 0 && sg[i] && q_nonempty[i]) begin q = i; is_strict = 1; end
      if (q >= 0) return;
      for (int k = 0; k <= 8 && q < 0; k++) begin
         int r = (m_rnd + k) % 8;
         int lo = (k == 0) ? m_ptr + 1 : 0;
         for (int i = lo; i < NQ && q < 0; i++)
            if (act[i] && !sg[i] && q_nonempty[i] && ((mask_of(m_prio[i]) >> r) & 1))
               begin q = i; rr = r; end
      end
   endtask

   task automatic check(bit ok, string rq, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic tick();
      int q, rr; bit st; bit any9; logic [7:0] eg;
      #2;
      model_pick(q, st, rr);
      eg = (q >= 0) ? (8'd1 << q) : 8'd0;
      any9 = 0;
      for (int i = 0; i < NQ; i++) any9 |= (m_prio[i] == 9);
      check(grant === eg, tag, "grant", grant, eg);
      check(grant_valid === (q >= 0), tag, "grant_valid", grant_valid, q >= 0);
      check(prio_err === m_err, "R5", "prio_err", prio_err, m_err);
      check(strict_present === any9, "R7", "strict_present", strict_present, any9);
      @(posedge clk);
      if (q >= 0) cnt[q]++;
      if (q >= 0 && !st) begin m_rnd = rr; m_ptr = q; end
      m_err = cfg_we && cfg_prio > 9;
      if (cfg_we) begin
         m_prio[cfg_addr] = cfg_prio; m_last[cfg_addr] = cfg_last; m_slast[cfg_addr] = cfg_slast;
      end
      @(negedge clk);
   endtask

   task automatic wr(int a, int p, bit l, bit s);
      cfg_we = 1; cfg_addr = 3'(a); cfg_prio = 4'(p); cfg_last = l; cfg_slast = s;
      tick();
      cfg_we = 0; cfg_last = 0; cfg_slast = 0;
   endtask

   task automatic clr_cnt();
      for (int i = 0; i < NQ; i++) cnt[i] = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] lf = 16'hACE1;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state, all requests, nothing granted
      tag = "R1"; q_nonempty = 8'hFF; ready = 1;
      tick();
      check(grant_valid === 1'b0, "R1", "reset no grant", grant_valid, 0);

      // R2/R9: weights 1,2,4,8 on q0..q3, port ends at q3
      tag = "R2"; ready = 0; q_nonempty = 0;
      wr(0, 1, 0, 0); wr(1, 2, 0, 0); wr(2, 4, 0, 0); wr(3, 8, 1, 0);
      clr_cnt(); q_nonempty = 8'hFF; ready = 1;
      repeat (60) tick();
      check(cnt[0] == 4,  "R2", "weight1 count", cnt[0], 4);
      check(cnt[1] == 8,  "R2", "weight2 count", cnt[1], 8);
      check(cnt[2] == 16, "R9", "weight4 count", cnt[2], 16);
      check(cnt[3] == 32, "R9", "weight8 count", cnt[3], 32);
      check(cnt[4] == 0,  "R6", "beyond last", cnt[4], 0);

      // R3 and R11: live rewrite to weight 0
      tag = "R11"; wr(1, 0, 0, 0);
      tag = "R3"; clr_cnt();
      repeat (30) tick();
      check(cnt[1] == 0, "R3", "weight0 never served", cnt[1], 0);

      // R2: remaining mask values with sparse requests
      tag = "R2";
      wr(0, 3, 0, 0); wr(1, 5, 0, 0); wr(2, 6, 0, 0); wr(3, 7, 1, 0);
      for (int p = 1; p < 16; p++) begin
         q_nonempty = 8'(p);
         repeat (9) tick();
      end

      // R4/R7: strict group q0..q1, weighted q2..q3
      tag = "R4"; q_nonempty = 8'hFF;
      wr(0, 9, 0, 0); wr(1, 9, 0, 1); wr(2, 4, 0, 0); wr(3, 4, 1, 0);
      tick();
      check(grant === 8'h01, "R4", "lowest strict wins", grant, 8'h01);
      q_nonempty = 8'hFE; tick();
      check(grant === 8'h02, "R4", "next strict", grant, 8'h02);
      q_nonempty = 8'h0C; repeat (10) tick();
      check(strict_present === 1'b1, "R7", "strict present", strict_present, 1);

      // R7: value 9 above the strict bound serves as weighted
      tag = "R7"; wr(0, 9, 0, 1); q_nonempty = 8'h02; tick();
      check(grant === 8'h02, "R7", "value9 beyond bound weighted", grant, 8'h02);
      q_nonempty = 8'h03; repeat (4) tick();

      // R5: invalid value stored as FF
      tag = "R5"; wr(2, 12, 0, 0);
      check(prio_err === 1'b1, "R5", "error pulse", prio_err, 1);
      q_nonempty = 8'h0C; repeat (8) tick();
      check(prio_err === 1'b0, "R5", "error cleared", prio_err, 0);

      // R10: ready low gives no grant
      tag = "R10"; ready = 0; q_nonempty = 8'hFF; repeat (3) tick();
      check(grant === 8'h00, "R10", "no grant without ready", grant, 0);
      ready = 1; q_nonempty = 8'h00; tick();
      check(grant_valid === 1'b0, "R10", "no eligible", grant_valid, 0);

      // R6: shrink the port to q0..q1
      tag = "R6"; wr(0, 8, 0, 0); wr(1, 8, 1, 0); clr_cnt();
      q_nonempty = 8'hFF; repeat (20) tick();
      check(cnt[2] + cnt[3] == 0, "R6", "queues above last", cnt[2] + cnt[3], 0);

      // R8/R9/R11: pseudo-random traffic and live rewrites
      tag = "R8";
      for (int n = 0; n < 3000; n++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         q_nonempty = lf[7:0];
         ready = lf[8] | lf[9];
         if (lf[3:0] == 4'h5)
            wr(int'(lf[6:4]), int'(lf[12:9]), lf[13] & lf[14], lf[15] & lf[1]);
         else tick();
      end
      ready = 0; q_nonempty = 0; tick();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule